// File: doc/BRIEF.md
# Spread-Spectrum PWM Switching Clock Generator

This block sets the switching-cycle timing of a current-mode converter controller. A phase accumulator, advanced once per system clock by a phase increment, wraps once per switching cycle. Each wrap opens a new cycle: the block raises its gate request and pulses a cycle-start strobe. The on-time ends at the earliest of two events. One is a trip of the current comparator. The other is the point where the phase reaches the maximum-duty fraction of the cycle. Neither event can end the pulse before a minimum on-time has elapsed.

To spread the energy of the switching harmonics, the phase increment is not fixed. A symmetric triangle sweeps it. An up/down step counter moves one step per switching cycle, so the switching frequency walks between its nominal value minus and plus a deviation. One select input picks between a slow variant (60 kHz nominal, 4 kHz deviation) and a fast variant (115 kHz nominal, 8 kHz deviation). All increments are computed at elaboration from the system clock parameter.

Top module: `jitter_pwm_clkgen`

## Requirements
- R1: While reset is high, `gate_req` and `cyc_start` are low. The first enabled clock edge after reset starts a switching cycle, so both outputs are high in the clock that follows that edge.
- R2: The mean switching period over one full sweep is within 1.5 % of CLK_HZ / F. F is F_LO_HZ (60 kHz) when `freq_hi` = 0 and F_HI_HZ (115 kHz) when `freq_hi` = 1.
- R3: Every period lies between CLK_HZ/(F+DEV) and CLK_HZ/(F-DEV), with a tolerance of one clock on each side. Both ends are reached within a sweep. DEV is 4 kHz for the slow variant and 8 kHz for the fast one.
- R4: The sweep is a triangle of Q = round(F / (4·MOD_HZ)) steps per quarter, with MOD_HZ = 230. It moves one step per switching cycle, so the period sequence repeats every 4·Q cycles, within one clock. The phase increment changes only at a cycle start.
- R5: `cyc_start` is a one-clock pulse at the start of each cycle. `gate_req` rises in that same clock.
- R6: Once the gate has been high for at least the minimum on-time, a comparator trip sampled high at a clock edge drops `gate_req` at that edge. A trip first sampled D+1 clocks into the pulse yields a pulse D+1 clocks wide.
- R7: The minimum on-time is MIN = ceil(TON_MIN_NS·CLK_HZ/1e9) clocks, with TON_MIN_NS = 480. A comparator trip during it is ignored. A trip held high from before the cycle start yields a pulse exactly MIN clocks wide.
- R8: With no trip, `gate_req` falls when the phase reaches DMAX_PCT (75) % of full scale. The pulse width is then within two clocks of 0.75 of that cycle's period.
- R9: While `en` is low, `gate_req` is low from the next clock and no `cyc_start` occurs. The phase and the sweep are held. On re-enable, the interrupted cycle completes with its remaining phase, and the gate stays low until the next cycle start.
- R10: A change of `freq_hi` takes effect at the next cycle start. The sweep then restarts from the new nominal frequency, and the cycle in progress keeps the old rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising-edge active |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds the timing state and blocks the gate |
| freq_hi | input | 1 | Variant select: 0 slow nominal rate, 1 fast nominal rate |
| cmp_trip | input | 1 | Peak-current comparator trip, active high |
| gate_req | output | 1 | Power switch on request |
| cyc_start | output | 1 | One-clock strobe marking each switching cycle start |

## Verification
The assertions assume a few things about the inputs. The comparator trip is already synchronous to the clock. The phase increment stays below half of full scale, so two wraps never fall on adjacent clocks. The minimum on-time ends well before the duty point. The bench respects these limits. It drives every input one nanosecond after a rising edge and keeps trip delays far inside the duty window. It changes the variant select and the enable only at known offsets from a cycle start, which lets each expected pulse width and period be derived from the requirement formulas.

// File: rtl/pwm_jit_pkg.sv
`timescale 1ns/1ps
package pwm_jit_pkg;

    localparam int PHASE_W = 32;

    typedef longint unsigned u64_t;
    typedef logic [PHASE_W-1:0] phase_t;

    typedef enum logic {
        SWEEP_UP   = 1'b0,
        SWEEP_DOWN = 1'b1
    } sweep_dir_e;

    // Per-variant sweep constants, computed at elaboration.
    typedef struct packed {
        phase_t      base;     // increment at nominal frequency
        phase_t      step;     // increment change per sweep step
        logic [15:0] quarter;  // sweep steps per quarter triangle
    } sweep_cfg_t;

    // Events raised by the phase accumulator for the current clock.
    typedef struct packed {
        logic wrap;  // phase rolls over: new switching cycle
        logic cap;   // phase at or past the duty ceiling
    } phase_evt_t;

    function automatic u64_t div_round(u64_t num, u64_t den);
        return (num + den / 2) / den;
    endfunction

    function automatic u64_t ceil_div_min1(u64_t num, u64_t den);
        u64_t q;
        q = (num + den - 1) / den;
        return (q == 0) ? 1 : q;
    endfunction

    function automatic sweep_cfg_t make_cfg(u64_t clk_hz, u64_t f_hz, u64_t dev_hz, u64_t mod_hz);
        sweep_cfg_t c;
        u64_t       q;
        q = div_round(f_hz, 4 * mod_hz);
        if (q == 0) q = 1;
        c.quarter = 16'(q);
        c.base    = phase_t'(div_round(f_hz << PHASE_W, clk_hz));
        c.step    = phase_t'(div_round(dev_hz << PHASE_W, clk_hz * q));
        return c;
    endfunction

    function automatic phase_t offset_inc(phase_t base, phase_t step, int pos);
        longint t;
        t = longint'(base) + longint'(pos) * longint'(step);
        return phase_t'(t);
    endfunction

    function automatic phase_t duty_threshold(int pct);
        return phase_t'((u64_t'(pct) << PHASE_W) / 100);
    endfunction

endpackage

// File: rtl/pwm_jit_sweep.sv
`timescale 1ns/1ps
module pwm_jit_sweep
    import pwm_jit_pkg::*;
#(
    parameter int CLK_HZ    = 50_000_000,
    parameter int F_LO_HZ   = 60_000,
    parameter int F_HI_HZ   = 115_000,
    parameter int DEV_LO_HZ = 4_000,
    parameter int DEV_HI_HZ = 8_000,
    parameter int MOD_HZ    = 230
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   freq_hi,
    output phase_t inc
);

    localparam sweep_cfg_t CFG_LO = make_cfg(u64_t'(CLK_HZ), u64_t'(F_LO_HZ), u64_t'(DEV_LO_HZ), u64_t'(MOD_HZ));
    localparam sweep_cfg_t CFG_HI = make_cfg(u64_t'(CLK_HZ), u64_t'(F_HI_HZ), u64_t'(DEV_HI_HZ), u64_t'(MOD_HZ));
    localparam int Q_MAX = (int'(CFG_LO.quarter) > int'(CFG_HI.quarter)) ?
                           int'(CFG_LO.quarter) : int'(CFG_HI.quarter);
    localparam int PW = $clog2(Q_MAX + 1) + 1;
    localparam logic signed [PW-1:0] ONE = 1;

    logic signed [PW-1:0] pos_q, pos_nxt, lim;
    sweep_dir_e           dir_q, dir_nxt;
    logic                 sel_q, sel_nxt;
    phase_t               inc_q, inc_nxt;
    sweep_cfg_t           cfg_cur, cfg_new;

    assign cfg_cur = sel_q   ? CFG_HI : CFG_LO;
    assign cfg_new = freq_hi ? CFG_HI : CFG_LO;
    assign lim     = $signed(PW'(cfg_cur.quarter));

    always_comb begin
        pos_nxt = pos_q;
        dir_nxt = dir_q;
        sel_nxt = sel_q;
        inc_nxt = inc_q;
        if (tick) begin
            if (freq_hi != sel_q) begin
                // variant change: restart the triangle at the new nominal rate
                sel_nxt = freq_hi;
                pos_nxt = '0;
                dir_nxt = SWEEP_UP;
                inc_nxt = cfg_new.base;
            end else begin
                pos_nxt = (dir_q == SWEEP_UP) ? pos_q + ONE : pos_q - ONE;
                if (pos_nxt == lim)
                    dir_nxt = SWEEP_DOWN;
                else if (pos_nxt == -lim)
                    dir_nxt = SWEEP_UP;
                inc_nxt = offset_inc(cfg_cur.base, cfg_cur.step, int'(pos_nxt));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
            dir_q <= SWEEP_UP;
            sel_q <= 1'b0;
            inc_q <= CFG_LO.base;
        end else begin
            pos_q <= pos_nxt;
            dir_q <= dir_nxt;
            sel_q <= sel_nxt;
            inc_q <= inc_nxt;
        end
    end

    assign inc = inc_q;

    // R4
    sweep_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (pos_q <= lim) && (pos_q >= -lim));

    // R4
    inc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(inc_q));

endmodule

// File: rtl/pwm_phase_accum.sv
`timescale 1ns/1ps
module pwm_phase_accum
    import pwm_jit_pkg::*;
#(
    parameter int DMAX_PCT = 75
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  phase_t     inc,
    output phase_evt_t evt
);

    localparam phase_t DUTY_THR = duty_threshold(DMAX_PCT);

    phase_t             acc_q;
    logic [PHASE_W:0]   sum;

    assign sum      = {1'b0, acc_q} + {1'b0, inc};
    assign evt.wrap = en && sum[PHASE_W];
    assign evt.cap  = en && !sum[PHASE_W] && (sum[PHASE_W-1:0] >= DUTY_THR);

    // Reset to full scale so the first enabled edge opens a cycle.
    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '1;
        else if (en)
            acc_q <= sum[PHASE_W-1:0];
    end

    // R9
    phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(acc_q));

    // R5
    wrap_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        evt.wrap |=> !evt.wrap);

endmodule

// File: rtl/pwm_gate_ctrl.sv
`timescale 1ns/1ps
module pwm_gate_ctrl
    import pwm_jit_pkg::*;
#(
    parameter int MIN_CLKS = 24
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       trip,
    input  phase_evt_t evt,
    output logic       gate,
    output logic       start
);

    localparam int CW = $clog2(MIN_CLKS + 1);

    logic          gate_q, cs_q, blank_done;
    logic [CW-1:0] cnt_q;

    assign blank_done = (cnt_q == CW'(MIN_CLKS));

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= 1'b0;
            cs_q   <= 1'b0;
            cnt_q  <= '0;
        end else begin
            cs_q <= evt.wrap;
            if (!en) begin
                gate_q <= 1'b0;
                cnt_q  <= '0;
            end else if (evt.wrap) begin
                gate_q <= 1'b1;
                cnt_q  <= CW'(1);
            end else if (gate_q) begin
                if (blank_done && (trip || evt.cap))
                    gate_q <= 1'b0;
                else if (!blank_done)
                    cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    assign gate  = gate_q;
    assign start = cs_q;

    // R7
    blank_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (en && gate_q && !blank_done) |=> gate_q);

    // R6
    trip_off_chk: assert property (@(posedge clk) disable iff (rst)
        (en && gate_q && blank_done && trip && !evt.wrap) |=> !gate_q);

    // R8
    duty_off_chk: assert property (@(posedge clk) disable iff (rst)
        (en && gate_q && blank_done && evt.cap) |=> !gate_q);

    // R9
    idle_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!gate_q && !cs_q));

    // R5
    cycle_open_chk: assert property (@(posedge clk) disable iff (rst)
        evt.wrap |=> (cs_q && gate_q));

endmodule

// File: rtl/jitter_pwm_clkgen.sv
`timescale 1ns/1ps
module jitter_pwm_clkgen
    import pwm_jit_pkg::*;
#(
    parameter int CLK_HZ     = 50_000_000,
    parameter int F_LO_HZ    = 60_000,
    parameter int F_HI_HZ    = 115_000,
    parameter int DEV_LO_HZ  = 4_000,
    parameter int DEV_HI_HZ  = 8_000,
    parameter int MOD_HZ     = 230,
    parameter int DMAX_PCT   = 75,
    parameter int TON_MIN_NS = 480
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic freq_hi,
    input  logic cmp_trip,
    output logic gate_req,
    output logic cyc_start
);

    localparam int MIN_CLKS = int'(ceil_div_min1(u64_t'(TON_MIN_NS) * u64_t'(CLK_HZ),
                                                 u64_t'(1_000_000_000)));

    phase_t     inc;
    phase_evt_t evt;

    pwm_jit_sweep #(
        .CLK_HZ    (CLK_HZ),
        .F_LO_HZ   (F_LO_HZ),
        .F_HI_HZ   (F_HI_HZ),
        .DEV_LO_HZ (DEV_LO_HZ),
        .DEV_HI_HZ (DEV_HI_HZ),
        .MOD_HZ    (MOD_HZ)
    ) u_sweep (
        .clk     (clk),
        .rst     (rst),
        .tick    (evt.wrap),
        .freq_hi (freq_hi),
        .inc     (inc)
    );

    pwm_phase_accum #(
        .DMAX_PCT (DMAX_PCT)
    ) u_accum (
        .clk (clk),
        .rst (rst),
        .en  (en),
        .inc (inc),
        .evt (evt)
    );

    pwm_gate_ctrl #(
        .MIN_CLKS (MIN_CLKS)
    ) u_gate (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .trip  (cmp_trip),
        .evt   (evt),
        .gate  (gate_req),
        .start (cyc_start)
    );

endmodule

// File: tb/test_jitter_pwm_clkgen.sv
`timescale 1ns/1ps
module test_jitter_pwm_clkgen;

    localparam int CLK_HZ = 4_000_000;
    localparam int F_LO   = 60_000;
    localparam int F_HI   = 115_000;
    localparam int DEV_LO = 4_000;
    localparam int DEV_HI = 8_000;
    localparam int MODF   = 230;
    localparam int DMAX   = 75;
    localparam int MIN_CLK = int'((longint'(480) * longint'(CLK_HZ) + 64'd999_999_999) / 64'd1_000_000_000);
    localparam int Q_LO   = (F_LO + 2 * MODF) / (4 * MODF);
    localparam int Q_HI   = (F_HI + 2 * MODF) / (4 * MODF);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b1;
    logic freq_hi = 1'b0;
    logic cmp_trip = 1'b0;
    logic gate_req, cyc_start;

    always #2 clk = ~clk;

    jitter_pwm_clkgen #(.CLK_HZ(CLK_HZ)) i_jitter_pwm_clkgen (
        .clk(clk), .rst(rst), .en(en), .freq_hi(freq_hi), .cmp_trip(cmp_trip),
        .gate_req(gate_req), .cyc_start(cyc_start)
    );

    typedef struct { int per; int wid; } cyc_rec_t;
    typedef struct { string tag; int width; } exp_t;
    cyc_rec_t cyc_log[$];
    exp_t     exp_q[$];

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic check(string tag, bit ok, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: logs period/width per cycle and scores expected pulse widths.
    int   since_start = 0;
    int   cur_wid = 0;
    bit   seen_start = 1'b0;
    logic gate_prev = 1'b0;
    always @(negedge clk) begin
        if (rst) begin
            since_start = 0; cur_wid = 0; seen_start = 1'b0; gate_prev = 1'b0;
        end else begin
            since_start++;
            if (cyc_start === 1'b1) begin
                if (seen_start) cyc_log.push_back('{per: since_start, wid: cur_wid});
                seen_start = 1'b1; since_start = 0; cur_wid = 0;
            end
            if (gate_req === 1'b1) cur_wid++;
            if (gate_prev && gate_req !== 1'b1 && exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.tag, cur_wid == e.width, cur_wid, e.width);
            end
            gate_prev = gate_req;
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wait_start();
        do step(); while (cyc_start !== 1'b1);
    endtask

    // Driver: pushes the expected width, then trips D clocks after the rise.
    task automatic trip_after(string tag, int d);
        wait_start();
        exp_q.push_back('{tag: tag, width: (d + 1 < MIN_CLK) ? MIN_CLK : d + 1});
        if (d > 0) repeat (d) step();
        cmp_trip = 1'b1;
        while (gate_req === 1'b1) step();
        cmp_trip = 1'b0;
    endtask

    task automatic analyse(string sfx, int s, int f, int dev, int q);
        real ideal, pmin, pmax, mean;
        int  sum4, mn, mx, bad_rng, bad_rep, bad_duty, lo_b, hi_b, p, w, dd;
        ideal = real'(CLK_HZ) / f;
        pmin  = real'(CLK_HZ) / (f + dev);
        pmax  = real'(CLK_HZ) / (f - dev);
        lo_b  = int'($floor(pmin)) - 1;
        hi_b  = int'($ceil(pmax)) + 1;
        sum4 = 0; mn = 1000000; mx = 0; bad_rng = 0; bad_rep = 0; bad_duty = 0;
        for (int i = s; i < s + 8 * q; i++) begin
            p = cyc_log[i].per;
            w = cyc_log[i].wid;
            if (i < s + 4 * q) sum4 += p;
            if (p < mn) mn = p;
            if (p > mx) mx = p;
            if (p < lo_b || p > hi_b) bad_rng++;
            dd = w * 100 - DMAX * p;
            if (dd > 200 || dd < -200) bad_duty++;
        end
        for (int i = s; i < s + 4 * q; i++) begin
            dd = cyc_log[i].per - cyc_log[i + 4 * q].per;
            if (dd > 1 || dd < -1) bad_rep++;
        end
        mean = real'(sum4) / (4 * q);
        check({"R2 mean period x1000 ", sfx}, (mean - ideal <= 0.015 * ideal) && (ideal - mean <= 0.015 * ideal),
              int'(mean * 1000.0), int'(ideal * 1000.0));
        check({"R3 periods out of range ", sfx}, bad_rng == 0, bad_rng, 0);
        check({"R3 shortest period ", sfx}, mn <= int'($ceil(pmin)) + 1, mn, int'($ceil(pmin)) + 1);
        check({"R3 longest period ", sfx}, mx >= int'($floor(pmax)) - 1, mx, int'($floor(pmax)) - 1);
        check({"R4 sweep repeat mismatches ", sfx}, bad_rep == 0, bad_rep, 0);
        check({"R8 duty ceiling violations ", sfx}, bad_duty == 0, bad_duty, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int k, bad, bad2;
        // R1: reset state
        repeat (4) step();
        check("R1 gate in reset", gate_req === 1'b0, gate_req, 0);
        check("R1 strobe in reset", cyc_start === 1'b0, cyc_start, 0);
        rst = 1'b0;
        step();
        check("R1 first cycle strobe", cyc_start === 1'b1, cyc_start, 1);
        check("R5 gate rises with strobe", gate_req === 1'b1, gate_req, 1);
        step();
        check("R5 strobe one clock", cyc_start === 1'b0, cyc_start, 0);

        // R2 R3 R4 R8: slow variant over two sweeps
        wait_start();
        cyc_log.delete();
        while (cyc_log.size() < 1 + 8 * Q_LO) step();
        analyse("slow", 1, F_LO, DEV_LO, Q_LO);

        // R6 R7: comparator trips
        trip_after("R7 trip at rise ignored", 0);
        trip_after("R7 trip at blank boundary", 1);
        trip_after("R6 trip 5 clocks in", 5);
        trip_after("R6 trip 20 clocks in", 20);
        while (gate_req === 1'b1) step();
        cmp_trip = 1'b1;
        wait_start();
        exp_q.push_back('{tag: "R7 held trip gives minimum width", width: MIN_CLK});
        while (gate_req === 1'b1) step();
        cmp_trip = 1'b0;

        // R9: enable low mid-pulse
        wait_start();
        repeat (10) step();
        en = 1'b0;
        bad = 0;
        repeat (40) begin
            step();
            if (gate_req !== 1'b0 || cyc_start !== 1'b0) bad++;
        end
        check("R9 outputs low while disabled", bad == 0, bad, 0);
        en = 1'b1;
        k = 0; bad2 = 0;
        do begin
            step(); k++;
            if (cyc_start !== 1'b1 && gate_req !== 1'b0) bad2++;
        end while (cyc_start !== 1'b1 && k < 200);
        check("R9 gate stays low until next start", bad2 == 0, bad2, 0);
        check("R9 interrupted cycle length", (10 + k >= 61) && (10 + k <= 73), 10 + k, 67);

        // R10: switch to the fast variant right after a cycle start
        wait_start();
        freq_hi = 1'b1;
        cyc_log.delete();
        while (cyc_log.size() < 3 + 8 * Q_HI) step();
        check("R10 cycle in progress keeps slow rate",
              cyc_log[1].per >= 61 && cyc_log[1].per <= 73, cyc_log[1].per, 67);
        check("R10 first fast cycle at nominal",
              cyc_log[2].per >= 34 && cyc_log[2].per <= 36, cyc_log[2].per, 35);
        analyse("fast", 2, F_HI, DEV_HI, Q_HI);
        trip_after("R6 trip 8 clocks in fast", 8);
        repeat (40) step();
        check("R6 scoreboard drained", exp_q.size() == 0, exp_q.size(), 0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule